// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single input line. An external tick arrives at sixteen times the bit rate, and the receiver takes every sample on that tick. A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional odd or even parity bit, then a stop bit. The receiver checks one stop bit in every mode. A transmitter that sends two stop bits is still accepted, because the second stop bit looks like idle line.

Each completed word goes into a receive data register. The block then raises a full flag and a level interrupt. Three status bits report errors: a parity mismatch, a stop bit sampled low (framing), and a word that completed while the register was still full (overrun). A one-cycle read strobe tells the block that the data register was read. It clears the full flag and all error flags. Bit-rate timer generation and bus decoding are outside this block.

Top module: `uart_rx_err`

## Requirements
- R1: All line sampling happens on `tick16` pulses. A start bit is confirmed on the 8th tick after the tick that detected the falling edge. Each later bit is sampled 16 ticks after the previous sample.
- R2: `cfg_eight`=1 selects 8 data bits and `cfg_eight`=0 selects 7 data bits. Data bits are received least significant bit first, and bit i of the frame lands in `rx_data[i]`.
- R3: `cfg_par_en`=1 adds a parity bit after the data. `cfg_par_odd`=1 selects odd parity, meaning data ones plus the parity bit make an odd count. `cfg_par_odd`=0 selects even parity.
- R4: In 7-bit mode, `rx_data[7]` reads 0.
- R5: `err_parity` is set with the word when the received parity bit does not match the selected parity. It stays 0 when parity is disabled.
- R6: `err_frame` is set with the word when the stop bit is sampled low.
- R7: Only one stop bit is checked. A new start bit that directly follows a single stop bit is received correctly.
- R8: If a word completes while `rx_full` is 1 and no read strobe is present, `err_overrun` is set. The held word and its other flags are kept, and the new word is discarded.
- R9: If the line is high again at the start-bit check, the start is rejected, and no word or flag results.
- R10: `rd_strobe` clears `rx_full`, `err_parity`, `err_frame` and `err_overrun`. `rx_irq` is high exactly while `rx_full` is 1. Any error flag being set implies `rx_full` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial input line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_strobe | input | 1 | Data register read; clears full and error flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Data register holds an unread word |
| err_parity | output | 1 | Parity error on the held word |
| err_frame | output | 1 | Framing error on the held word |
| err_overrun | output | 1 | A word was lost while the register was full |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Some properties are checked by the assertions on every cycle. An error flag is never set without `rx_full`. Overrun only rises while a word is already held. The held word stays stable until it is read. A new word only appears on a tick. A 7-bit word always loads with a zero top bit. Other behaviour can only be shown by the bench's scenarios: the mid-bit sampling points, least-significant-first ordering, odd and even parity results, glitch rejection, and a frame that starts right after a single stop bit. Those scenarios send whole frames with a known timing and compare the register contents after each one.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic       cfg_eight,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       rx_irq
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] CNT_MID  = CW'(MID - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic          rx_prev;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          pbit;

  wire       rx_s      = sync[1];
  wire       sample    = tick16 && (cnt == CNT_FULL);
  wire       last_data = bidx == (cfg_eight ? 3'd7 : 3'd6);
  wire [7:0] word      = cfg_eight ? sh : {1'b0, sh[7:1]};
  wire       perr      = cfg_par_en && ((^word ^ pbit) != cfg_par_odd);
  wire       done      = (st == S_STOP) && sample;
  wire       can_load  = !rx_full || rd_strobe;

  assign rx_irq = rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b0;
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      pbit    <= 1'b0;
    end else begin
      sync <= {sync[0], rx_in};
      if (tick16) rx_prev <= rx_s;
      case (st)
        S_IDLE:
          if (tick16 && rx_prev && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick16) begin
            if (cnt == CNT_MID) begin
              cnt  <= '0;
              bidx <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_DATA:
          if (sample) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[7:1]};
            bidx <= bidx + 1'b1;
            if (last_data) st <= cfg_par_en ? S_PAR : S_STOP;
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        S_PAR:
          if (sample) begin
            cnt  <= '0;
            pbit <= rx_s;
            st   <= S_STOP;
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        S_STOP:
          if (sample) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else if (tick16) begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done && can_load) begin
      rx_data     <= word;
      rx_full     <= 1'b1;
      err_parity  <= perr;
      err_frame   <= !rx_s;
      err_overrun <= 1'b0;
    end else if (done) begin
      err_overrun <= 1'b1;
    end else if (rd_strobe) begin
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end
  end
endmodule

module uart_rx_err_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       cfg_eight,
  input logic       rd_strobe,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun
);
  p_err_implies_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity || err_frame || err_overrun) |-> rx_full);

  p_overrun_when_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full));

  p_held_word_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_strobe) |=> $stable(rx_data));

  p_load_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(tick16));

  p_msb_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && !$past(cfg_eight)) |-> !rx_data[7]);
endmodule

bind uart_rx_err uart_rx_err_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_eight(cfg_eight),
  .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
  .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/sim_uart_rx_err.sv
`timescale 1ns/1ps
module sim_uart_rx_err;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 0, rst_n = 0, rx_in = 1, tick16 = 0;
  logic cfg_eight = 1, cfg_par_en = 0, cfg_par_odd = 0, rd_strobe = 0;
  logic [7:0] rx_data;
  logic rx_full, err_parity, err_frame, err_overrun, rx_irq;
  int checks = 0, fails = 0;
  int tcnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TDIV - 1);
  end

  uart_rx_err u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rx_in = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] d, input logic pbad, input logic stop_v);
    int nb = cfg_eight ? 8 : 7;
    logic p = cfg_par_odd ^ pbad;
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      hold_bit(d[i]);
      p = p ^ d[i];
    end
    if (cfg_par_en) hold_bit(p);
    hold_bit(stop_v);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic check_word(input string req, input int d, input int pe, input int fe, input int oe);
    chk({req, " full"}, rx_full, 1);
    chk({req, " irq"}, rx_irq, 1);
    chk({req, " data"}, rx_data, d);
    chk({req, " parity"}, err_parity, pe);
    chk({req, " frame"}, err_frame, fe);
    chk({req, " overrun"}, err_overrun, oe);
  endtask

  task automatic t_reset();
    chk("R10 reset full", rx_full, 0);
    chk("R10 reset irq", rx_irq, 0);
    chk("R10 reset data", rx_data, 0);
    chk("R10 reset errs", {err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_eight_plain();
    cfg_eight = 1; cfg_par_en = 0;
    send_word(8'hA5, 0, 1); idle(32);
    check_word("R1 R2 8bit A5", 8'hA5, 0, 0, 0);
    do_read();
    chk("R10 read clears full", rx_full, 0);
    chk("R10 irq follows full", rx_irq, 0);
  endtask

  task automatic t_seven_even();
    cfg_eight = 0; cfg_par_en = 1; cfg_par_odd = 0;
    send_word(8'hDA, 0, 1); idle(32);
    check_word("R3 R4 7bit even", 8'h5A, 0, 0, 0);
    do_read();
  endtask

  task automatic t_eight_odd();
    cfg_eight = 1; cfg_par_en = 1; cfg_par_odd = 1;
    send_word(8'h83, 0, 1); idle(32);
    check_word("R3 8bit odd", 8'h83, 0, 0, 0);
    do_read();
  endtask

  task automatic t_parity_err();
    cfg_eight = 1; cfg_par_en = 1; cfg_par_odd = 0;
    send_word(8'h3C, 1, 1); idle(32);
    check_word("R5 bad parity", 8'h3C, 1, 0, 0);
    do_read();
    chk("R10 read clears parity", err_parity, 0);
  endtask

  task automatic t_frame_err();
    cfg_eight = 0; cfg_par_en = 0;
    send_word(8'h12, 0, 0); idle(32);
    check_word("R6 stop low", 8'h12, 0, 1, 0);
    do_read();
    chk("R10 read clears frame", err_frame, 0);
  endtask

  task automatic t_overrun();
    cfg_eight = 1; cfg_par_en = 0;
    send_word(8'h11, 0, 1); idle(16);
    send_word(8'h22, 0, 1); idle(32);
    check_word("R8 overrun keeps old", 8'h11, 0, 0, 1);
    do_read();
    chk("R10 read clears overrun", err_overrun, 0);
    chk("R10 read clears full after overrun", rx_full, 0);
  endtask

  task automatic t_glitch();
    cfg_eight = 1; cfg_par_en = 0;
    rx_in = 0;
    repeat (2 * TDIV) @(negedge clk);
    idle(12 * BITCLK);
    chk("R9 glitch no word", rx_full, 0);
    chk("R9 glitch no flags", {err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_back_to_back();
    cfg_eight = 1; cfg_par_en = 0;
    send_word(8'h6E, 0, 1);
    check_word("R7 first frame", 8'h6E, 0, 0, 0);
    fork
      send_word(8'hC3, 0, 1);
      begin repeat (8) @(negedge clk); rd_strobe = 1; @(negedge clk) rd_strobe = 0; end
    join
    idle(32);
    check_word("R7 second frame after one stop", 8'hC3, 0, 0, 0);
    do_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    idle(40);
    t_eight_plain();
    t_seven_even();
    t_eight_odd();
    t_parity_err();
    t_frame_err();
    idle(40);
    t_overrun();
    t_glitch();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule